// File: doc/BRIEF.md
# Parallel Flash Bus-Mode Decoder and Command Front-End

This block sits between the strobe pins of a byte-wide parallel flash memory and its storage. On every clock it turns the active-low chip-enable, output-enable and write-enable strobes into one bus mode: standby, output disable, read, identifier read or write. The high-voltage flag on address bit 9 also takes part in the decision. The block drives the data-bus enable and chooses whether the output byte comes from the array or from a fixed identifier code. A small behavioural array stands in for real storage.

Writes go to a command register. It accepts them only while the programming-voltage flag is high and the low-supply lockout flag is clear. With the programming voltage low, the register is held at the read command, so the part is read-only. Programming and erasing each take two bus writes: a setup command, then a data byte or a confirm. A bad confirm aborts the sequence, and a data write that has no setup in front of it does nothing.

The strobes are sampled on a system clock. The address is captured when write-enable falls. The command byte is taken when write-enable rises, provided chip-enable is still low.

Top module: `flash_bus_frontend`

## Requirements
- R1: `busMode` encodes 0 = standby, 1 = output disable, 2 = read, 3 = identifier read, 4 = write. Chip-enable high always gives standby. With chip-enable low: output-enable high and write-enable high give 1; output-enable high and write-enable low give 4; output-enable low and write-enable high give 2, or 3 when `a9HighV` is set or the command register holds the identifier command.
- R2: `dataOe` is high only in modes 2 and 3.
- R3: In a read with `a9HighV` set, `dataOut` is 0x89 when address bit 0 is low and 0xBD when it is high. This holds at either programming-voltage level.
- R4: After reset the command register holds read, and array byte `a` reads as (a*29+3) mod 256.
- R5: Writing 0x90 with the programming voltage high makes reads return the identifier codes of R3 without `a9HighV`. Writing 0x00 returns reads to array data.
- R6: Writing 0x40 and then data D at address A sets byte A to (old AND D), and the register returns to read.
- R7: Writing 0x20 and then 0x20 sets every array byte to 0xFF, and the register returns to read.
- R8: After 0x20, any second byte other than 0x20 aborts the sequence. The array is left unchanged and the register returns to read.
- R9: A data write while the register holds read, with no setup before it, leaves the array unchanged.
- R10: While `vppHigh` is low, writes are ignored and the register is forced to read, so identifier-by-command mode ends.
- R11: While `lowSupply` is high, writes are ignored and the register keeps its current command.
- R12: Chip-enable, output-enable and write-enable all low gives output disable (mode 1). The bus is not driven, and no command is taken when write-enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| a9HighV | input | 1 | High-voltage level present on address bit 9 |
| vppHigh | input | 1 | Programming voltage present |
| lowSupply | input | 1 | Supply below write-lockout threshold |
| dataIn | input | 8 | Data bus input |
| dataOut | output | 8 | Data bus output value |
| dataOe | output | 1 | Data bus drive enable (low = tri-state) |
| busMode | output | 3 | Decoded bus mode (R1 encoding) |

## Verification
Bus mode, drive enable and output byte are combinational, so they are due in the same cycle as the strobes that cause them. The bench therefore samples them shortly after it drives new inputs at the falling clock edge. A command or array update lands at the first rising edge where write-enable is seen high after being low. The bench holds each strobe phase for two clock cycles, so each result is settled before the next phase, and only then issues the read that checks it. Checks on ignored writes read the affected array byte, or the identifier state, back through an ordinary read.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_OUTDIS  = 3'd1,
    MODE_READ    = 3'd2,
    MODE_IDENT   = 3'd3,
    MODE_WRITE   = 3'd4
  } busMode_e;

  typedef enum logic [1:0] {
    CST_READ,
    CST_IDENT,
    CST_ERASE_SETUP,
    CST_PROG_SETUP
  } cmdState_e;

  typedef struct packed {
    logic addrCapture;
    logic progStrobe;
    logic eraseStrobe;
    logic idSelect;
  } feStrobes_t;

  localparam logic [7:0] MFR_CODE = 8'h89;
  localparam logic [7:0] DEV_CODE = 8'hBD;
  localparam int INIT_MUL = 29;
  localparam int INIT_ADD = 3;
endpackage

// File: rtl/flash_fe_ctrl.sv
module flash_fe_ctrl
  import flash_fe_pkg::*;
#(
  parameter logic [7:0] CMD_RD    = 8'h00,
  parameter logic [7:0] CMD_ID    = 8'h90,
  parameter logic [7:0] CMD_ERASE = 8'h20,
  parameter logic [7:0] CMD_PROG  = 8'h40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       a9HighV,
  input  logic       vppHigh,
  input  logic       lowSupply,
  input  logic [7:0] dataIn,
  output logic [2:0] busMode,
  output logic       dataOe,
  output feStrobes_t strobes
);
  logic      weSeen;
  logic      armed;
  logic      weFall;
  logic      weRise;
  logic      wrOk;
  cmdState_e cmdState;
  busMode_e  modeNow;

  assign weFall = !ceN && weSeen && !weN;
  assign weRise = !ceN && armed && !weSeen && weN && oeN;
  assign wrOk   = vppHigh && !lowSupply;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weSeen <= 1'b1;
      armed  <= 1'b0;
    end else begin
      weSeen <= weN;
      if (weFall)
        armed <= oeN;
      else if (!weSeen && weN)
        armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdState <= CST_READ;
    end else if (!vppHigh) begin
      cmdState <= CST_READ;
    end else if (weRise && wrOk) begin
      unique case (cmdState)
        CST_READ, CST_IDENT: begin
          if (dataIn == CMD_ID)
            cmdState <= CST_IDENT;
          else if (dataIn == CMD_ERASE)
            cmdState <= CST_ERASE_SETUP;
          else if (dataIn == CMD_PROG)
            cmdState <= CST_PROG_SETUP;
          else
            cmdState <= CST_READ;
        end
        default: cmdState <= CST_READ;
      endcase
    end
  end

  always_comb begin
    strobes.addrCapture = weFall && oeN;
    strobes.progStrobe  = weRise && wrOk && (cmdState == CST_PROG_SETUP);
    strobes.eraseStrobe = weRise && wrOk && (cmdState == CST_ERASE_SETUP)
                          && (dataIn == CMD_ERASE);
    strobes.idSelect    = (cmdState == CST_IDENT);
  end

  always_comb begin
    if (ceN) begin
      modeNow = MODE_STANDBY;
    end else begin
      unique case ({oeN, weN})
        2'b01:   modeNow = (a9HighV || strobes.idSelect) ? MODE_IDENT : MODE_READ;
        2'b10:   modeNow = MODE_WRITE;
        default: modeNow = MODE_OUTDIS;
      endcase
    end
  end

  assign busMode = modeNow;
  assign dataOe  = (modeNow == MODE_READ) || (modeNow == MODE_IDENT);
endmodule

// File: rtl/flash_fe_datapath.sv
module flash_fe_datapath
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              a9HighV,
  input  feStrobes_t        strobes,
  output logic [7:0]        dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addrLatch;

  always_ff @(posedge clk) begin
    if (!rstN)
      addrLatch <= '0;
    else if (strobes.addrCapture)
      addrLatch <= addr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= 8'((i * INIT_MUL + INIT_ADD) % 256);
    end else if (strobes.eraseStrobe) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= 8'hFF;
    end else if (strobes.progStrobe) begin
      mem[addrLatch] <= mem[addrLatch] & dataIn;
    end
  end

  always_comb begin
    if (a9HighV || strobes.idSelect)
      dataOut = addr[0] ? DEV_CODE : MFR_CODE;
    else
      dataOut = mem[addr];
  end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter logic [7:0] CMD_RD    = 8'h00,
  parameter logic [7:0] CMD_ID    = 8'h90,
  parameter logic [7:0] CMD_ERASE = 8'h20,
  parameter logic [7:0] CMD_PROG  = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              a9HighV,
  input  logic              vppHigh,
  input  logic              lowSupply,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic [2:0]        busMode
);
  feStrobes_t strobes;

  flash_fe_ctrl #(
    .CMD_RD(CMD_RD), .CMD_ID(CMD_ID), .CMD_ERASE(CMD_ERASE), .CMD_PROG(CMD_PROG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .a9HighV(a9HighV), .vppHigh(vppHigh), .lowSupply(lowSupply),
    .dataIn(dataIn), .busMode(busMode), .dataOe(dataOe), .strobes(strobes)
  );

  flash_fe_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .a9HighV(a9HighV), .strobes(strobes), .dataOut(dataOut)
  );
endmodule

// File: rtl/flash_fe_checker.sv
module flash_fe_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic       weN,
  input logic       a9HighV,
  input logic       addr0,
  input logic       vppHigh,
  input logic       lowSupply,
  input logic [2:0] busMode,
  input logic       dataOe,
  input logic [7:0] dataOut,
  input logic       progStrobe,
  input logic       eraseStrobe
);
  a_r1_standby_on_ce_high: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> busMode == 3'd0);

  a_r2_drive_only_in_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!ceN && !oeN && weN));

  a_r3_ident_codes: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && weN && a9HighV) |-> dataOut == (addr0 ? 8'hBD : 8'h89));

  a_r10_vpp_low_no_alter: assert property (@(posedge clk) disable iff (!rstN)
    !vppHigh |-> !(progStrobe || eraseStrobe));

  a_r11_lockout_no_alter: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |-> !(progStrobe || eraseStrobe));

  a_r12_all_low_outdis: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !weN) |-> (busMode == 3'd1 && !dataOe));
endmodule

bind flash_bus_frontend flash_fe_checker u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .a9HighV(a9HighV), .addr0(addr[0]), .vppHigh(vppHigh), .lowSupply(lowSupply),
  .busMode(busMode), .dataOe(dataOe), .dataOut(dataOut),
  .progStrobe(strobes.progStrobe), .eraseStrobe(strobes.eraseStrobe)
);

// File: tb/tb_flash_bus_frontend.sv
module tb_flash_bus_frontend;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              ceN, oeN, weN, a9HighV, vppHigh, lowSupply;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        dataIn;
  logic [7:0]        dataOut;
  logic              dataOe;
  logic [2:0]        busMode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  flash_bus_frontend #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .a9HighV(a9HighV), .vppHigh(vppHigh), .lowSupply(lowSupply),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .busMode(busMode)
  );

  // {ceN, oeN, weN, a9, a0, vpp, mode[2:0], oe, data[7:0]}
  localparam logic [17:0] VEC [10] = '{
    {6'b100000, 3'd0, 1'b0, 8'h00},
    {6'b101111, 3'd0, 1'b0, 8'h00},
    {6'b011000, 3'd1, 1'b0, 8'h00},
    {6'b001000, 3'd2, 1'b1, 8'h03},
    {6'b001011, 3'd2, 1'b1, 8'h20},
    {6'b001100, 3'd3, 1'b1, 8'h89},
    {6'b001111, 3'd3, 1'b1, 8'hBD},
    {6'b010000, 3'd4, 1'b0, 8'h00},
    {6'b000000, 3'd1, 1'b0, 8'h00},
    {6'b111000, 3'd0, 1'b0, 8'h00}
  };

  function automatic logic [7:0] initByte(int a);
    return 8'((a * 29 + 3) % 256);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; weN = 1'b1; addr = a; a9HighV = 1'b0;
    @(negedge clk); weN = 1'b0; dataIn = d;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic readCheck(string tag, logic [ADDR_W-1:0] a, logic [7:0] exp);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a; a9HighV = 1'b0;
    #1;
    check(tag, dataOut, exp);
    check({tag, " oe"}, {7'd0, dataOe}, 8'd1);
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; addr = '0;
    a9HighV = 1'b0; vppHigh = 1'b0; lowSupply = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R2 reset no drive", {7'd0, dataOe}, 8'd0);
    check("R1 reset standby", {5'd0, busMode}, 8'd0);
    readCheck("R4 reset array byte 7", 4'd7, initByte(7));

    // R1 R2 R3 vector walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {ceN, oeN, weN, a9HighV} = VEC[i][17:14];
      addr = {3'd0, VEC[i][13]};
      vppHigh = VEC[i][12];
      #1;
      check($sformatf("R1 vec %0d mode", i), {5'd0, busMode}, {5'd0, VEC[i][11:9]});
      check($sformatf("R2 vec %0d oe", i), {7'd0, dataOe}, {7'd0, VEC[i][8]});
      if (VEC[i][8]) check($sformatf("R3 R4 vec %0d data", i), dataOut, VEC[i][7:0]);
    end
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; weN = 1'b1; a9HighV = 1'b0;
    vppHigh = 1'b1;

    // R5 identifier by command
    busWrite(4'd0, 8'h90);
    readCheck("R5 id mfr", 4'd0, 8'h89);
    readCheck("R5 id dev", 4'd1, 8'hBD);
    busWrite(4'd0, 8'h00);
    readCheck("R5 back to array", 4'd1, initByte(1));

    // R6 program then back to read
    busWrite(4'd0, 8'h40);
    busWrite(4'd5, 8'h0F);
    readCheck("R6 programmed byte", 4'd5, initByte(5) & 8'h0F);
    readCheck("R6 neighbour intact", 4'd4, initByte(4));
    busWrite(4'd5, 8'hF0);
    readCheck("R6 R9 register back to read", 4'd5, initByte(5) & 8'h0F);

    // R9 data write without setup
    busWrite(4'd2, 8'h55);
    readCheck("R9 no setup", 4'd2, initByte(2));

    // R8 erase aborted
    busWrite(4'd0, 8'h20);
    busWrite(4'd0, 8'h33);
    readCheck("R8 abort byte 0", 4'd0, initByte(0));
    busWrite(4'd7, 8'h0F);
    readCheck("R8 returned to read", 4'd7, initByte(7));

    // R10 programming voltage low
    busWrite(4'd0, 8'h90);
    readCheck("R10 id before drop", 4'd0, 8'h89);
    @(negedge clk); vppHigh = 1'b0;
    @(negedge clk);
    readCheck("R10 forced read", 4'd0, initByte(0));
    busWrite(4'd0, 8'h40);
    @(negedge clk); vppHigh = 1'b1;
    busWrite(4'd3, 8'h00);
    readCheck("R10 setup ignored", 4'd3, initByte(3));

    // R11 lockout
    @(negedge clk); lowSupply = 1'b1;
    busWrite(4'd0, 8'h40);
    @(negedge clk); lowSupply = 1'b0;
    busWrite(4'd6, 8'h00);
    readCheck("R11 setup ignored", 4'd6, initByte(6));
    busWrite(4'd0, 8'h90);
    @(negedge clk); lowSupply = 1'b1;
    busWrite(4'd0, 8'h00);
    readCheck("R11 command held", 4'd0, 8'h89);
    @(negedge clk); lowSupply = 1'b0;
    busWrite(4'd0, 8'h00);

    // R12 all strobes low
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b0; dataIn = 8'h40; addr = 4'd1;
    @(negedge clk); #1;
    check("R12 mode outdis", {5'd0, busMode}, 8'd1);
    check("R12 no drive", {7'd0, dataOe}, 8'd0);
    @(negedge clk); weN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    busWrite(4'd1, 8'h00);
    readCheck("R12 no command taken", 4'd1, initByte(1));

    // R7 erase then program
    busWrite(4'd0, 8'h20);
    busWrite(4'd0, 8'h20);
    readCheck("R7 erased byte 0", 4'd0, 8'hFF);
    readCheck("R7 erased byte 5", 4'd5, 8'hFF);
    busWrite(4'd0, 8'h40);
    busWrite(4'd7, 8'hA5);
    readCheck("R7 R6 program after erase", 4'd7, 8'hA5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule